// File: doc/BRIEF.md
# VGA Raster Sync and Timing Generator

This block produces the raster timing for a VGA monitor. It runs from a 25 MHz pixel clock, which is close enough to the nominal 25.175 MHz. A combinational timing table is indexed by a mode code. It supplies the active and total column and line counts, and the begin and end addresses of both sync pulses. Only one table entry exists, 640x480, and every mode code falls back to it.

Two free-running counters walk the raster. The column counter runs across a line. The line counter steps each time the column counter wraps. Downstream pixel logic reads the current column and line. It also receives an active-video flag, which is registered so that it lines up with the sync outputs.

Both sync outputs are active low. Each comes from comparing its counter against the begin and end addresses from the table, and each edge is registered one clock after the comparison matches. A synchronous enable forces both syncs to their inactive level. The counters keep running while enable is low.

Top module: `vga_raster_sync`

## Requirements
- R1: While reset is high and on the first sample after it, column and line are 0, hsyncN and vsyncN are 1, and activeVideo is 0.
- R2: The column counter counts 0 to H_TOTAL-1 and then wraps to 0. The line counter increments by one on that wrap and holds otherwise.
- R3: The line counter wraps from V_TOTAL-1 to 0 when the column counter wraps on the last line.
- R4: hsyncN is active low. With enable high it goes to 0 on the clock after column equals H_SYNC_BEGIN, returns to 1 on the clock after column equals H_SYNC_END, and otherwise keeps its value.
- R5: vsyncN follows the same rule as R4, comparing line against V_SYNC_BEGIN and V_SYNC_END.
- R6: While enable is low, both syncs are 1 on the next clock. After enable returns, a sync stays 1 until its begin address is matched again. The counters are not affected by enable.
- R7: activeVideo is 1 in the cycle after one in which column < H_ACTIVE and line < V_ACTIVE, and is 0 otherwise.
- R8: The default entry is 640x480: 800 columns per line and 525 lines per frame. hsyncN is low while the previous cycle's column is in 656..751, and vsyncN is low while the previous cycle's line is in 490..491.
- R9: The timing table is combinational, and every modeSel code selects the 640x480 entry. Changing modeSel has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Sync enable; low forces both syncs inactive |
| modeSel | input | MODE_W | Resolution mode code for the timing table |
| column | output | DIM_W | Current column counter |
| line | output | DIM_W | Current line counter |
| activeVideo | output | 1 | Visible-area flag, delayed one clock |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |

## Verification
A wrong counter shows up at the column and line ports on the very next sample. A sync register stuck, or flipped on the wrong match, shows up on hsyncN within one line, and on vsyncN within one frame of a small configuration. An off-by-one in the compare placement moves a sync or activeVideo edge by exactly one clock. For that reason the sweeps compare every output on every cycle, including the sync span boundaries, the wraps and enable toggles in the middle of a span.

// File: rtl/vga_raster_pkg.sv
package vga_raster_pkg;
  localparam int DIM_W  = 12;
  localparam int MODE_W = 3;

  typedef struct packed {
    logic [DIM_W-1:0] colActive;
    logic [DIM_W-1:0] colTotal;
    logic [DIM_W-1:0] lineActive;
    logic [DIM_W-1:0] lineTotal;
    logic [DIM_W-1:0] hBegin;
    logic [DIM_W-1:0] hEnd;
    logic [DIM_W-1:0] vBegin;
    logic [DIM_W-1:0] vEnd;
  } timing_t;

  // strobes from the counter control to the sync datapath
  typedef struct packed {
    logic hBeginHit;
    logic hEndHit;
    logic vBeginHit;
    logic vEndHit;
    logic inActive;
  } strobe_t;
endpackage

// File: rtl/vga_mode_table.sv
module vga_mode_table
  import vga_raster_pkg::*;
#(
  parameter int H_ACTIVE     = 640,
  parameter int H_TOTAL      = 800,
  parameter int H_SYNC_BEGIN = 656,
  parameter int H_SYNC_END   = 752,
  parameter int V_ACTIVE     = 480,
  parameter int V_TOTAL      = 525,
  parameter int V_SYNC_BEGIN = 490,
  parameter int V_SYNC_END   = 492
) (
  input  logic [MODE_W-1:0] modeSel,
  output timing_t           timing
);
  localparam logic [MODE_W-1:0] MODE_VGA480 = '0;

  timing_t entryVga480;

  always_comb begin
    entryVga480.colActive  = DIM_W'(H_ACTIVE);
    entryVga480.colTotal   = DIM_W'(H_TOTAL);
    entryVga480.lineActive = DIM_W'(V_ACTIVE);
    entryVga480.lineTotal  = DIM_W'(V_TOTAL);
    entryVga480.hBegin     = DIM_W'(H_SYNC_BEGIN);
    entryVga480.hEnd       = DIM_W'(H_SYNC_END);
    entryVga480.vBegin     = DIM_W'(V_SYNC_BEGIN);
    entryVga480.vEnd       = DIM_W'(V_SYNC_END);
  end

  always_comb begin
    case (modeSel)
      MODE_VGA480: timing = entryVga480;
      default:     timing = entryVga480;  // only supported entry
    endcase
  end
endmodule

// File: rtl/vga_raster_ctrl.sv
module vga_raster_ctrl
  import vga_raster_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  timing_t          timing,
  output logic [DIM_W-1:0] column,
  output logic [DIM_W-1:0] line,
  output strobe_t          strobes
);
  logic lineEnd;
  logic frameEnd;

  always_comb begin
    lineEnd  = (column == timing.colTotal - DIM_W'(1));
    frameEnd = (line == timing.lineTotal - DIM_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      column <= '0;
      line   <= '0;
    end else if (lineEnd) begin
      column <= '0;
      line   <= frameEnd ? '0 : line + DIM_W'(1);
    end else begin
      column <= column + DIM_W'(1);
    end
  end

  always_comb begin
    strobes.hBeginHit = (column == timing.hBegin);
    strobes.hEndHit   = (column == timing.hEnd);
    strobes.vBeginHit = (line == timing.vBegin);
    strobes.vEndHit   = (line == timing.vEnd);
    strobes.inActive  = (column < timing.colActive) && (line < timing.lineActive);
  end
endmodule

// File: rtl/vga_sync_dp.sv
module vga_sync_dp
  import vga_raster_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    enable,
  input  strobe_t strobes,
  output logic    hsyncN,
  output logic    vsyncN,
  output logic    activeVideo
);
  logic hNext;
  logic vNext;

  always_comb begin
    hNext = hsyncN;
    if (strobes.hBeginHit)    hNext = 1'b0;
    else if (strobes.hEndHit) hNext = 1'b1;
    vNext = vsyncN;
    if (strobes.vBeginHit)    vNext = 1'b0;
    else if (strobes.vEndHit) vNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsyncN      <= 1'b1;
      vsyncN      <= 1'b1;
      activeVideo <= 1'b0;
    end else begin
      hsyncN      <= enable ? hNext : 1'b1;
      vsyncN      <= enable ? vNext : 1'b1;
      activeVideo <= strobes.inActive;
    end
  end
endmodule

// File: rtl/vga_raster_sync.sv
module vga_raster_sync
  import vga_raster_pkg::*;
#(
  parameter int H_ACTIVE     = 640,
  parameter int H_TOTAL      = 800,
  parameter int H_SYNC_BEGIN = 656,
  parameter int H_SYNC_END   = 752,
  parameter int V_ACTIVE     = 480,
  parameter int V_TOTAL      = 525,
  parameter int V_SYNC_BEGIN = 490,
  parameter int V_SYNC_END   = 492
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [MODE_W-1:0] modeSel,
  output logic [DIM_W-1:0]  column,
  output logic [DIM_W-1:0]  line,
  output logic              activeVideo,
  output logic              hsyncN,
  output logic              vsyncN
);
  timing_t timing;
  strobe_t strobes;

  vga_mode_table #(
    .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL),
    .H_SYNC_BEGIN(H_SYNC_BEGIN), .H_SYNC_END(H_SYNC_END),
    .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL),
    .V_SYNC_BEGIN(V_SYNC_BEGIN), .V_SYNC_END(V_SYNC_END)
  ) u_table (
    .modeSel(modeSel),
    .timing(timing)
  );

  vga_raster_ctrl u_ctrl (
    .clk(clk),
    .rst(rst),
    .timing(timing),
    .column(column),
    .line(line),
    .strobes(strobes)
  );

  vga_sync_dp u_dp (
    .clk(clk),
    .rst(rst),
    .enable(enable),
    .strobes(strobes),
    .hsyncN(hsyncN),
    .vsyncN(vsyncN),
    .activeVideo(activeVideo)
  );
endmodule

// File: rtl/vga_raster_chk.sv
module vga_raster_chk
  import vga_raster_pkg::*;
#(
  parameter int H_ACTIVE     = 640,
  parameter int H_TOTAL      = 800,
  parameter int H_SYNC_BEGIN = 656,
  parameter int H_SYNC_END   = 752,
  parameter int V_ACTIVE     = 480,
  parameter int V_TOTAL      = 525,
  parameter int V_SYNC_BEGIN = 490,
  parameter int V_SYNC_END   = 492
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic [DIM_W-1:0] column,
  input logic [DIM_W-1:0] line,
  input logic             activeVideo,
  input logic             hsyncN,
  input logic             vsyncN
);
  localparam logic [DIM_W-1:0] COL_LAST  = DIM_W'(H_TOTAL - 1);
  localparam logic [DIM_W-1:0] LINE_LAST = DIM_W'(V_TOTAL - 1);
  localparam logic [DIM_W-1:0] HB = DIM_W'(H_SYNC_BEGIN);
  localparam logic [DIM_W-1:0] HE = DIM_W'(H_SYNC_END);
  localparam logic [DIM_W-1:0] VB = DIM_W'(V_SYNC_BEGIN);
  localparam logic [DIM_W-1:0] VE = DIM_W'(V_SYNC_END);
  localparam logic [DIM_W-1:0] HA = DIM_W'(H_ACTIVE);

  AST_COL_WRAP: assert property (@(posedge clk) disable iff (rst)
    column == COL_LAST |=> column == '0);  // R2
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
    (column == COL_LAST && line != LINE_LAST) |=> line == $past(line) + DIM_W'(1));  // R2
  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (column == COL_LAST && line == LINE_LAST) |=> line == '0);  // R3
  AST_HSYNC_START: assert property (@(posedge clk) disable iff (rst)
    (enable && column == HB) |=> !hsyncN);  // R4
  AST_HSYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (enable && column != HB && column != HE) |=> hsyncN == $past(hsyncN));  // R4
  AST_VSYNC_START: assert property (@(posedge clk) disable iff (rst)
    (enable && line == VB) |=> !vsyncN);  // R5
  AST_VSYNC_STOP: assert property (@(posedge clk) disable iff (rst)
    (enable && line == VE) |=> vsyncN);  // R5
  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (hsyncN && vsyncN));  // R6
  AST_BLANK_RIGHT: assert property (@(posedge clk) disable iff (rst)
    column >= HA |=> !activeVideo);  // R7
endmodule

bind vga_raster_sync vga_raster_chk #(
  .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL),
  .H_SYNC_BEGIN(H_SYNC_BEGIN), .H_SYNC_END(H_SYNC_END),
  .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL),
  .V_SYNC_BEGIN(V_SYNC_BEGIN), .V_SYNC_END(V_SYNC_END)
) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .column(column), .line(line),
  .activeVideo(activeVideo), .hsyncN(hsyncN), .vsyncN(vsyncN)
);

// File: tb/vga_raster_sync_bench.sv
module vga_raster_sync_bench;
  import vga_raster_pkg::*;

  // small configuration for full-frame sweeps
  localparam int SHA = 8, SHT = 12, SHB = 9, SHE = 10;
  localparam int SVA = 4, SVT = 7,  SVB = 5, SVE = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enS = 1'b1;
  logic enD = 1'b1;
  logic [MODE_W-1:0] modeS = '0;
  logic [MODE_W-1:0] modeD = '0;
  logic [DIM_W-1:0] colS, lineS, colD, lineD;
  logic actS, hS, vS, actD, hD, vD;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vga_raster_sync #(
    .H_ACTIVE(SHA), .H_TOTAL(SHT), .H_SYNC_BEGIN(SHB), .H_SYNC_END(SHE),
    .V_ACTIVE(SVA), .V_TOTAL(SVT), .V_SYNC_BEGIN(SVB), .V_SYNC_END(SVE)
  ) u_vga_raster_sync (
    .clk(clk), .rst(rst), .enable(enS), .modeSel(modeS),
    .column(colS), .line(lineS), .activeVideo(actS), .hsyncN(hS), .vsyncN(vS)
  );

  vga_raster_sync u_default (
    .clk(clk), .rst(rst), .enable(enD), .modeSel(modeD),
    .column(colD), .line(lineD), .activeVideo(actD), .hsyncN(hD), .vsyncN(vD)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finishRun();
  end

  initial begin
    int mc, ml, eh, ev, ea;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "column", int'(colS), 0);
    chk("R1", "line", int'(lineS), 0);
    chk("R1", "hsyncN", int'(hS), 1);
    chk("R1", "vsyncN", int'(vS), 1);
    chk("R1", "activeVideo", int'(actS), 0);
    chk("R1", "default hsyncN", int'(hD), 1);
    rst = 1'b0;
    chk("R1", "column after release", int'(colS), 0);

    // small config: three frames plus, with enable toggled mid span
    mc = 0; ml = 0; eh = 1; ev = 1; ea = 0;
    for (int i = 0; i < 3 * SHT * SVT + 20; i++) begin
      enS = !((i >= 33 && i < 36) || (i >= 3 * SHT * SVT - 40 && i < 3 * SHT * SVT - 28));
      modeS = MODE_W'(i);
      // expected next values from the requirement rules
      if (!enS) begin
        eh = 1; ev = 1;
      end else begin
        if (mc == SHB) eh = 0; else if (mc == SHE) eh = 1;
        if (ml == SVB) ev = 0; else if (ml == SVE) ev = 1;
      end
      ea = (mc < SHA && ml < SVA) ? 1 : 0;
      if (mc == SHT - 1) begin
        mc = 0;
        ml = (ml == SVT - 1) ? 0 : ml + 1;
      end else mc++;
      @(negedge clk);
      chk("R2", "column", int'(colS), mc);
      chk("R3", "line", int'(lineS), ml);
      chk("R4", "hsyncN", int'(hS), eh);
      chk("R5", "vsyncN", int'(vS), ev);
      chk("R7", "activeVideo", int'(actS), ea);
      if (!enS) chk("R6", "syncs idle", int'(hS & vS), 1);
    end

    // default 640x480 entry, modeSel changing every cycle (R8, R9)
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int n = 1; n <= 2 * 800 + 50; n++) begin
      int pc, pl;
      modeD = MODE_W'(n * 5);
      @(negedge clk);
      pc = (n - 1) % 800;
      pl = ((n - 1) / 800) % 525;
      chk("R8", "column", int'(colD), n % 800);
      chk("R9", "line", int'(lineD), (n / 800) % 525);
      chk("R8", "hsyncN", int'(hD), (pc >= 656 && pc <= 751) ? 0 : 1);
      chk("R8", "vsyncN", int'(vD), (pl >= 490 && pl <= 491) ? 0 : 1);
      chk("R9", "activeVideo", int'(actD), (pc < 640 && pl < 480) ? 1 : 0);
    end
    finishRun();
  end
endmodule